// File: doc/BRIEF.md
# Registered Configurable Multiplier

A single-clock multiplier for two W-bit operands (default 16). Each operand sits in its own input register, which has its own hold control and its own flag that picks two's complement or unsigned magnitude. Any mix of signed and unsigned operands gives the correct 2W-bit product. A rounding flag, captured with the operands, adds a half-LSB of the upper result half. The product is then presented either as the full 2W-bit value or as a left-shifted (2W-1)-bit value with a sign copy placed in the top bit of the lower half.

The formatted product is stored in a result register that can be held, or made transparent so that the outputs follow the arithmetic without waiting for a clock. A selector steers either result half onto the upper output port. The lower half also goes out on the port whose pins are shared with the B operand input. Each three-state port is modelled as a data bus plus a drive-enable output. All control pins are plain levels. The block takes data every cycle and has no back-pressure, so it has no valid/ready handshake.

Top module: `pmul_core`

## Requirements
- R1: On a rising clock edge each operand register loads its data and its signed flag only when its hold input is low. While the hold input is high the register keeps its value and keeps the flag it was loaded with.
- R2: A signed flag of 1 makes its operand two's complement and 0 makes it unsigned. The 2W-bit product is correct for all four flag pairs.
- R3: The rounding flag is captured on a clock edge when at least one operand hold input is low. If both holds are high it keeps its old value. When set, it adds 2^(W-1) to the product in full format, and the carry out of bit 2W-1 is discarded.
- R4: With full_fmt = 1 the upper result half is P[2W-1:W] and the lower half is P[W-1:0].
- R5: With full_fmt = 0 the upper half is P[2W-2:W-1] and the lower half is {P[2W-1], P[W-2:0]}. Rounding then adds 2^(W-2) before the shift.
- R6: The result register loads the formatted product on a clock edge while res_hold is low. It keeps its value while res_hold is high.
- R7: With res_pass = 1 and res_hold = 0 the output ports follow the formatted product of the current operand registers in the same cycle. With res_hold = 1 the ports show the held register instead.
- R8: hi_sel_lo = 0 puts the upper result half on hi_port. hi_sel_lo = 1 puts the lower half on hi_port. lo_port always carries the lower half.
- R9: hi_drive is high exactly when hi_oe_n is low. lo_drive is high exactly when lo_oe_n is low.
- R10: While lo_drive is high, the shared pins carry lo_port, so the B operand register loads the lower result half in place of b_in.
- R11: A synchronous active-high reset clears the operand registers, their flags, the rounding flag and the result register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Operand A data |
| a_tc | input | 1 | Operand A two's complement flag |
| a_hold | input | 1 | High keeps the A register |
| b_in | input | W | Operand B data (input side of the shared pins) |
| b_tc | input | 1 | Operand B two's complement flag |
| b_hold | input | 1 | High keeps the B register |
| rnd_req | input | 1 | Rounding request |
| full_fmt | input | 1 | 1: full product, 0: shifted product with sign copy |
| res_hold | input | 1 | High keeps the result register |
| res_pass | input | 1 | Transparent result path (when res_hold low) |
| hi_sel_lo | input | 1 | 0: upper half on hi_port, 1: lower half |
| hi_oe_n | input | 1 | Drive enable of hi_port, active low |
| lo_oe_n | input | 1 | Drive enable of lo_port onto the shared pins, active low |
| hi_port | output | W | Upper output port data |
| hi_drive | output | 1 | hi_port driven |
| lo_port | output | W | Lower result half for the shared pins |
| lo_drive | output | 1 | Shared pins driven by lo_port |

## Verification
A corrupted operand register, signed flag or rounding flag appears as a wrong product on the ports two clock edges after the load, or one edge later when the result path is transparent. A result register that fails to hold shows up after the next edge. A mis-steered half shows up at once when hi_sel_lo changes. The bench sweeps corner operand values over every flag, rounding and format combination, and checks both halves against an arithmetic reference. Directed cases cover holds, transparency and the shared-pin loop.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic {FMT_SHIFTED = 1'b0, FMT_FULL = 1'b1} fmt_e;
  typedef enum logic {HI_UPPER = 1'b0, HI_LOWER = 1'b1} hi_src_e;
endpackage

// File: rtl/pmul_opreg.sv
module pmul_opreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  input  logic         tc_d,
  output logic [W-1:0] q,
  output logic         tc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      tc_q <= 1'b0;
    end else if (!hold) begin
      q    <= d;
      tc_q <= tc_d;
    end
  end
endmodule

// File: rtl/pmul_arith.sv
module pmul_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic           a_tc,
  input  logic [W-1:0]   b,
  input  logic           b_tc,
  input  logic           rnd,
  input  logic           full_fmt,
  output logic [2*W-1:0] r
);
  import pmul_pkg::*;
  localparam int PW = 2 * W;
  localparam int XW = PW + 2;
  localparam logic [PW-1:0] RND_FULL  = PW'(1) << (W - 1);
  localparam logic [PW-1:0] RND_SHORT = PW'(1) << (W - 2);

  logic signed [W:0]    ea, eb;
  logic signed [XW-1:0] xa, xb, xp;
  logic [PW-1:0]        p, radd;
  fmt_e                 fmt;

  // operand extension: a set flag repeats the top bit, a clear one pads zero
  assign ea = {a_tc & a[W-1], a};
  assign eb = {b_tc & b[W-1], b};
  assign xa = {{(W+1){ea[W]}}, ea};
  assign xb = {{(W+1){eb[W]}}, eb};
  assign xp = xa * xb;

  assign fmt  = fmt_e'(full_fmt);
  assign radd = !rnd ? '0 : ((fmt == FMT_FULL) ? RND_FULL : RND_SHORT);
  assign p    = xp[PW-1:0] + radd;

  always_comb begin
    if (fmt == FMT_FULL) r = p;
    else                 r = {p[PW-2:W-1], p[PW-1], p[W-2:0]};
  end
endmodule

// File: rtl/pmul_result.sv
module pmul_result #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           pass,
  input  logic           sel_lo,
  input  logic [2*W-1:0] r_in,
  output logic [2*W-1:0] res_q,
  output logic [W-1:0]   hi_out,
  output logic [W-1:0]   lo_out
);
  import pmul_pkg::*;
  logic [2*W-1:0] view;
  hi_src_e        src;

  always_ff @(posedge clk) begin
    if (rst)        res_q <= '0;
    else if (!hold) res_q <= r_in;
  end

  assign view   = (pass && !hold) ? r_in : res_q;
  assign src    = hi_src_e'(sel_lo);
  assign hi_out = (src == HI_LOWER) ? view[W-1:0] : view[2*W-1:W];
  assign lo_out = view[W-1:0];
endmodule

// File: rtl/pmul_core.sv
module pmul_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_tc,
  input  logic         a_hold,
  input  logic [W-1:0] b_in,
  input  logic         b_tc,
  input  logic         b_hold,
  input  logic         rnd_req,
  input  logic         full_fmt,
  input  logic         res_hold,
  input  logic         res_pass,
  input  logic         hi_sel_lo,
  input  logic         hi_oe_n,
  input  logic         lo_oe_n,
  output logic [W-1:0] hi_port,
  output logic         hi_drive,
  output logic [W-1:0] lo_port,
  output logic         lo_drive
);
  logic [W-1:0]   a_q, b_q, b_pin;
  logic           a_tc_q, b_tc_q, rnd_q;
  logic [2*W-1:0] arith_r, res_q;

  // shared pins: when driven they carry the lower half back into B
  assign b_pin = lo_drive ? lo_port : b_in;

  pmul_opreg #(.W(W)) u_opa (
    .clk(clk), .rst(rst), .hold(a_hold), .d(a_in), .tc_d(a_tc),
    .q(a_q), .tc_q(a_tc_q)
  );

  pmul_opreg #(.W(W)) u_opb (
    .clk(clk), .rst(rst), .hold(b_hold), .d(b_pin), .tc_d(b_tc),
    .q(b_q), .tc_q(b_tc_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                   rnd_q <= 1'b0;
    else if (!a_hold || !b_hold) rnd_q <= rnd_req;
  end

  pmul_arith #(.W(W)) u_arith (
    .a(a_q), .a_tc(a_tc_q), .b(b_q), .b_tc(b_tc_q),
    .rnd(rnd_q), .full_fmt(full_fmt), .r(arith_r)
  );

  pmul_result #(.W(W)) u_res (
    .clk(clk), .rst(rst), .hold(res_hold), .pass(res_pass),
    .sel_lo(hi_sel_lo), .r_in(arith_r), .res_q(res_q),
    .hi_out(hi_port), .lo_out(lo_port)
  );

  assign hi_drive = !hi_oe_n;
  assign lo_drive = !lo_oe_n;
endmodule

// File: rtl/pmul_core_chk.sv
module pmul_core_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           a_hold,
  input logic           b_hold,
  input logic           res_hold,
  input logic           res_pass,
  input logic           hi_sel_lo,
  input logic [W-1:0]   a_q,
  input logic           a_tc_q,
  input logic [W-1:0]   b_q,
  input logic           b_tc_q,
  input logic           rnd_q,
  input logic [2*W-1:0] arith_r,
  input logic [2*W-1:0] res_q,
  input logic [W-1:0]   hi_port,
  input logic [W-1:0]   lo_port
);
  AST_OPA_HELD: assert property (@(posedge clk) disable iff (rst)
    a_hold |=> ($stable(a_q) && $stable(a_tc_q))); // R1
  AST_OPB_HELD: assert property (@(posedge clk) disable iff (rst)
    b_hold |=> ($stable(b_q) && $stable(b_tc_q))); // R1
  AST_RND_HELD: assert property (@(posedge clk) disable iff (rst)
    (a_hold && b_hold) |=> $stable(rnd_q)); // R3
  AST_RES_HELD: assert property (@(posedge clk) disable iff (rst)
    res_hold |=> $stable(res_q)); // R6
  AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (res_pass && !res_hold) |-> (lo_port == arith_r[W-1:0])); // R7
  AST_STEER_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!hi_sel_lo && (!res_pass || res_hold)) |-> (hi_port == res_q[2*W-1:W])); // R8
  AST_STEER_LOWER: assert property (@(posedge clk) disable iff (rst)
    (hi_sel_lo && (!res_pass || res_hold)) |-> (hi_port == res_q[W-1:0])); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (a_q == '0 && b_q == '0 && res_q == '0 && !rnd_q)); // R11
endmodule

bind pmul_core pmul_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_hold(a_hold), .b_hold(b_hold),
  .res_hold(res_hold), .res_pass(res_pass), .hi_sel_lo(hi_sel_lo),
  .a_q(a_q), .a_tc_q(a_tc_q), .b_q(b_q), .b_tc_q(b_tc_q), .rnd_q(rnd_q),
  .arith_r(arith_r), .res_q(res_q), .hi_port(hi_port), .lo_port(lo_port)
);

// File: tb/tb_pmul_core.sv
module tb_pmul_core;
  localparam int PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_tc = 0, a_hold = 0, b_tc = 0, b_hold = 0, rnd_req = 0, full_fmt = 0;
  logic res_hold = 0, res_pass = 0, hi_sel_lo = 0, hi_oe_n = 0, lo_oe_n = 1;
  logic [W-1:0] hi_port, lo_port;
  logic hi_drive, lo_drive;
  int n_run = 0, n_fail = 0;

  pmul_core #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_tc(a_tc), .a_hold(a_hold),
    .b_in(b_in), .b_tc(b_tc), .b_hold(b_hold), .rnd_req(rnd_req),
    .full_fmt(full_fmt), .res_hold(res_hold), .res_pass(res_pass),
    .hi_sel_lo(hi_sel_lo), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n),
    .hi_port(hi_port), .hi_drive(hi_drive), .lo_port(lo_port), .lo_drive(lo_drive)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic as,
                                          input logic [15:0] b, input logic bs,
                                          input logic rnd, input logic full);
    longint va, vb, p;
    logic [31:0] p32;
    va = as ? longint'($signed(a)) : longint'(a);
    vb = bs ? longint'($signed(b)) : longint'(b);
    p = va * vb + (rnd ? (full ? 64'd32768 : 64'd16384) : 64'd0);
    p32 = p[31:0];
    return full ? p32 : {p32[30:15], p32[31], p32[14:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a, input logic as, input logic [15:0] b,
                      input logic bs, input logic rnd, input logic full);
    @(negedge clk);
    a_in = a; a_tc = as; b_in = b; b_tc = bs; rnd_req = rnd; full_fmt = full;
    a_hold = 0; b_hold = 0; res_hold = 0; res_pass = 0; hi_sel_lo = 0; lo_oe_n = 1;
    settle(2);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    logic [31:0] e;
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
    settle(3);
    rst = 0;
    settle(1);
    check("R11 reset hi", 32'(hi_port), 32'h0);
    check("R11 reset lo", 32'(lo_port), 32'h0);
    check("R9 hi drive on", 32'(hi_drive), 32'h1);
    check("R9 lo drive off", 32'(lo_drive), 32'h0);

    // R2 R3 R4 R5 R8 sweep
    for (int ia = 0; ia < 6; ia++)
      for (int ib = 0; ib < 6; ib++)
        for (int m = 0; m < 16; m++) begin
          load(vals[ia], m[0], vals[ib], m[1], m[2], m[3]);
          e = ref_mul(vals[ia], m[0], vals[ib], m[1], m[2], m[3]);
          check(m[3] ? "R2 R3 R4 upper" : "R2 R3 R5 upper", 32'(hi_port), 32'(e[31:16]));
          check(m[3] ? "R4 lower" : "R5 lower", 32'(lo_port), 32'(e[15:0]));
          hi_sel_lo = 1;
          #1;
          check("R8 lower steered", 32'(hi_port), 32'(e[15:0]));
        end

    // R1 hold data
    load(16'd3, 0, 16'd5, 0, 0, 1);
    check("R1 base", {hi_port, lo_port}, 32'd15);
    a_hold = 1; a_in = 16'd7;
    settle(2);
    check("R1 A held", {hi_port, lo_port}, 32'd15);
    // R1 hold keeps signedness
    load(16'hFFFF, 1, 16'd2, 1, 0, 1);
    check("R2 signed -1*2", {hi_port, lo_port}, 32'hFFFFFFFE);
    a_hold = 1; a_tc = 0;
    settle(2);
    check("R1 flag held", {hi_port, lo_port}, 32'hFFFFFFFE);
    // R3 rnd not captured with both holds high
    b_hold = 1; rnd_req = 1;
    settle(2);
    check("R3 rnd blocked", {hi_port, lo_port}, 32'hFFFFFFFE);
    a_tc = 1; a_hold = 0;
    settle(2);
    check("R3 rnd captured carry dropped", {hi_port, lo_port}, 32'h00007FFE);

    // R6 result hold
    res_hold = 1; a_in = 16'd2; b_hold = 0; b_in = 16'd2; a_tc = 0; b_tc = 0; rnd_req = 0;
    settle(2);
    check("R6 held", {hi_port, lo_port}, 32'h00007FFE);
    res_hold = 0;
    settle(1);
    check("R6 released", {hi_port, lo_port}, 32'd4);

    // R7 transparent path
    res_pass = 1; a_in = 16'd3;
    settle(1);
    check("R7 pass one edge", 32'(lo_port), 32'd6);
    res_hold = 1; a_in = 16'd5;
    settle(1);
    check("R7 pass blocked by hold", 32'(lo_port), 32'd4);
    res_hold = 0;
    #1;
    check("R7 pass follows", 32'(lo_port), 32'd10);
    res_pass = 0;

    // R9 drive enables
    hi_oe_n = 1; lo_oe_n = 0;
    #1;
    check("R9 hi drive off", 32'(hi_drive), 32'h0);
    check("R9 lo drive on", 32'(lo_drive), 32'h1);
    hi_oe_n = 0; lo_oe_n = 1;

    // R10 shared pins loop back
    load(16'd1, 0, 16'h1234, 0, 0, 1);
    check("R10 base", 32'(lo_port), 32'h1234);
    lo_oe_n = 0; b_in = 16'hFFFF;
    settle(3);
    check("R10 B from pins", 32'(lo_port), 32'h1234);
    lo_oe_n = 1;
    settle(2);
    check("R10 B from b_in", 32'(lo_port), 32'hFFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule